// File: doc/BRIEF.md
# Legacy Memory Attribute Router

This block decides, for every processor memory access, whether the access is served by DRAM or forwarded to memory-mapped I/O. The decision covers the upper 256 KB of the first megabyte, where option ROMs and the boot firmware live. That area is cut into twelve 16 KB windows, each with its own 2-bit read/write attribute, plus one 64 KB firmware window at the top with a single attribute. Two fixed address holes can also be punched into DRAM: a 128 KB hole below the display area, or a 1 MB hole just under the 16 MB line.

Configuration is loaded through a simple byte-wide write port that selects one of eight attribute/hole bytes. Each access is presented with a valid strobe, its address and a write flag. One clock later the block raises a result strobe with the routing target and a flag that tells whether the address fell in a programmable region. Addresses outside every programmable region and outside an enabled hole go to DRAM.

Top module: `legacy_mem_router`

## Requirements
- R1: After reset `route_vld`, `route_io` and `route_hit` are 0 and every attribute and the hole control are 00, so every access in 0xC0000–0xFFFFF goes to I/O (`route_io`=1), whether it reads or writes.
- R2: `route_vld` is `acc_valid` delayed by exactly one clock; `route_io` and `route_hit` describe the access of that earlier cycle and hold their value in cycles after which no access was presented.
- R3: Attribute code 00 sends reads and writes to I/O, 01 sends reads to DRAM and writes to I/O, 10 sends writes to DRAM and reads to I/O, 11 sends both to DRAM (`route_io`=0 means DRAM, 1 means I/O).
- R4: Window k (k = 0..11) spans 0xC0000 + k·0x4000 to that base + 0x3FFF; its attribute is held in the byte written with `cfg_sel` = k/2 + 1, in bits [1:0] for even k and bits [5:4] for odd k. Any access in 0xC0000–0xFFFFF sets `route_hit`.
- R5: The window 0xF0000–0xFFFFF takes its attribute from bits [5:4] of the byte written with `cfg_sel` = 0; bits [1:0] of that byte have no effect.
- R6: Hole control is bits [7:6] of the byte written with `cfg_sel` = 7. Code 01 routes 0x80000–0x9FFFF to I/O with `route_hit`=1.
- R7: Hole code 10 routes 0xF00000–0xFFFFFF to I/O with `route_hit`=1.
- R8: Hole codes 00 and 11 open no hole: both hole ranges go to DRAM with `route_hit`=0.
- R9: Any address outside 0xC0000–0xFFFFF and outside an enabled hole, including addresses whose bits above bit 19 are nonzero, goes to DRAM with `route_hit`=0.
- R10: A configuration write with `cfg_sel` from 8 to 15 changes no routing.
- R11: A configuration write takes effect for accesses presented in later cycles; an access presented in the same cycle as the write is routed by the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_write | input | 1 | 1 = write access, 0 = read |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 4 | Configuration byte select |
| cfg_data | input | 8 | Configuration byte value |
| route_vld | output | 1 | Routing result valid, one clock after `acc_valid` |
| route_io | output | 1 | 1 = memory-mapped I/O, 0 = DRAM |
| route_hit | output | 1 | Access fell in a window or an enabled hole |

## Verification
The hardest situation to reach is a configuration write that lands in the same cycle as an access to the window it changes, because the outcome depends on which value the decoder sees at that edge. The bench drives both strobes on the same falling edge and then repeats the access alone, expecting the old attribute first and the new one after. The reserved hole code and writes to unused selects need the same care: they are reached by first programming a visible state and then checking that it survives.

// File: rtl/legacy_route_pkg.sv
package legacy_route_pkg;

    typedef enum logic [1:0] {
        ATTR_OFF     = 2'b00,
        ATTR_RD_DRAM = 2'b01,
        ATTR_WR_DRAM = 2'b10,
        ATTR_BOTH    = 2'b11
    } attr_e;

    typedef enum logic [1:0] {
        HOLE_NONE = 2'b00,
        HOLE_LOW  = 2'b01,
        HOLE_HIGH = 2'b10,
        HOLE_RSVD = 2'b11
    } hole_e;

    typedef enum logic {
        TGT_DRAM = 1'b0,
        TGT_MMIO = 1'b1
    } tgt_e;

endpackage

// File: rtl/lrt_attr_regs.sv
module lrt_attr_regs
    import legacy_route_pkg::*;
#(
    parameter int SEG_NUM = 12,
    parameter int SEL_W   = 4,
    parameter int DATA_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [SEL_W-1:0]          cfg_sel,
    input  logic [DATA_W-1:0]         cfg_data,
    output logic [SEG_NUM-1:0][1:0]   seg_attr,
    output attr_e                     bios_attr,
    output hole_e                     hole_mode
);
    localparam int PAIR_BYTES = (SEG_NUM + 1) / 2;
    localparam logic [SEL_W-1:0] BIOS_SEL = '0;
    localparam logic [SEL_W-1:0] HOLE_SEL = SEL_W'(PAIR_BYTES + 1);

    logic unused_bits;
    assign unused_bits = ^cfg_data[3:2];

    // one 2-bit field per window, two windows per select value
    for (genvar k = 0; k < SEG_NUM; k++) begin : g_seg
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(k / 2 + 1);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seg_attr[k] <= ATTR_OFF;
            end else if (cfg_we && cfg_sel == MY_SEL) begin
                if (k % 2 == 0) seg_attr[k] <= cfg_data[1:0];
                else            seg_attr[k] <= cfg_data[5:4];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bios_attr <= ATTR_OFF;
            hole_mode <= HOLE_NONE;
        end else if (cfg_we) begin
            if (cfg_sel == BIOS_SEL) bios_attr <= attr_e'(cfg_data[5:4]);
            if (cfg_sel == HOLE_SEL) hole_mode <= hole_e'(cfg_data[7:6]);
        end
    end

endmodule

// File: rtl/lrt_region_decode.sv
module lrt_region_decode
    import legacy_route_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SEG_NUM = 12
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [SEG_NUM-1:0][1:0]   seg_attr,
    input  attr_e                     bios_attr,
    input  hole_e                     hole_mode,
    output logic                      in_legacy,
    output logic                      in_hole,
    output attr_e                     win_attr
);
    localparam int SEG_LSB  = 14;
    localparam int IDX_W    = 4;
    localparam int MEG_LSB  = 20;
    localparam int HLO_LSB  = 17;
    localparam logic [ADDR_W-HLO_LSB-1:0] HLO_TAG = (ADDR_W-HLO_LSB)'(4);
    localparam logic [ADDR_W-MEG_LSB-1:0] HHI_TAG = (ADDR_W-MEG_LSB)'(15);

    logic [IDX_W-1:0] seg_idx;
    logic             low_meg;
    logic             unused_addr;

    assign unused_addr = ^addr[SEG_LSB-1:0];
    assign seg_idx     = addr[SEG_LSB+IDX_W-1:SEG_LSB];
    assign low_meg     = (addr[ADDR_W-1:MEG_LSB] == '0);

    always_comb begin
        in_legacy = low_meg && (addr[MEG_LSB-1:MEG_LSB-2] == 2'b11);
        unique case (hole_mode)
            HOLE_LOW:  in_hole = (addr[ADDR_W-1:HLO_LSB] == HLO_TAG);
            HOLE_HIGH: in_hole = (addr[ADDR_W-1:MEG_LSB] == HHI_TAG);
            HOLE_NONE,
            HOLE_RSVD: in_hole = 1'b0;
            default:   in_hole = 1'b0;
        endcase
        if (int'(seg_idx) < SEG_NUM) win_attr = attr_e'(seg_attr[seg_idx]);
        else                         win_attr = bios_attr;
    end

endmodule

// File: rtl/legacy_mem_router.sv
module legacy_mem_router
    import legacy_route_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SEG_NUM = 12,
    parameter int SEL_W   = 4,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_data,
    output logic              route_vld,
    output logic              route_io,
    output logic              route_hit
);
    logic [SEG_NUM-1:0][1:0] seg_attr;
    attr_e                   bios_attr;
    hole_e                   hole_cfg;
    attr_e                   win_attr;
    logic                    in_legacy;
    logic                    in_hole;
    tgt_e                    tgt_nxt;

    lrt_attr_regs #(
        .SEG_NUM (SEG_NUM),
        .SEL_W   (SEL_W),
        .DATA_W  (DATA_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_data  (cfg_data),
        .seg_attr  (seg_attr),
        .bios_attr (bios_attr),
        .hole_mode (hole_cfg)
    );

    lrt_region_decode #(
        .ADDR_W  (ADDR_W),
        .SEG_NUM (SEG_NUM)
    ) i_dec (
        .addr      (acc_addr),
        .seg_attr  (seg_attr),
        .bios_attr (bios_attr),
        .hole_mode (hole_cfg),
        .in_legacy (in_legacy),
        .in_hole   (in_hole),
        .win_attr  (win_attr)
    );

    // attr bit 0 lets reads reach DRAM, bit 1 lets writes reach DRAM
    always_comb begin
        logic [1:0] a;
        a = win_attr;
        if (in_hole)        tgt_nxt = TGT_MMIO;
        else if (in_legacy) tgt_nxt = (acc_write ? a[1] : a[0]) ? TGT_DRAM : TGT_MMIO;
        else                tgt_nxt = TGT_DRAM;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_vld <= 1'b0;
            route_io  <= 1'b0;
            route_hit <= 1'b0;
        end else begin
            route_vld <= acc_valid;
            if (acc_valid) begin
                route_io  <= (tgt_nxt == TGT_MMIO);
                route_hit <= in_hole || in_legacy;
            end
        end
    end

endmodule

// File: rtl/legacy_mem_router_chk.sv
module legacy_mem_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic [31:0] acc_addr,
    input logic        acc_write,
    input logic [1:0]  hole_mode,
    input logic        route_vld,
    input logic        route_io,
    input logic        route_hit
);
    logic in_lo, in_hi, outside;
    assign in_lo   = (acc_addr[31:17] == 15'd4);
    assign in_hi   = (acc_addr[31:20] == 12'h00F);
    assign outside = !(acc_addr[31:18] == 14'h3) && !in_lo && !in_hi;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !route_vld && !route_io && !route_hit);

    assert_vld_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> route_vld);

    assert_vld_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !route_vld && $stable(route_io) && $stable(route_hit));

    assert_window_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_addr[31:18] == 14'h3 |=> route_hit);

    assert_hole_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && hole_mode == 2'b01 && in_lo |=> route_io && route_hit);

    assert_hole_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && hole_mode == 2'b10 && in_hi |=> route_io && route_hit);

    assert_no_hole_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (hole_mode == 2'b00 || hole_mode == 2'b11) && (in_lo || in_hi)
        |=> !route_io && !route_hit);

    assert_outside_dram_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && outside |=> !route_io && !route_hit);

    logic unused_wr;
    assign unused_wr = acc_write;

endmodule

bind legacy_mem_router legacy_mem_router_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_write (acc_write),
    .hole_mode (hole_cfg),
    .route_vld (route_vld),
    .route_io  (route_io),
    .route_hit (route_hit)
);

// File: tb/test_legacy_mem_router.sv
`timescale 1ns/1ps
module test_legacy_mem_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [7:0]  cfg_data = '0;
    logic        route_vld, route_io, route_hit;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    legacy_mem_router i_legacy_mem_router (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .route_vld(route_vld), .route_io(route_io), .route_hit(route_hit)
    );

    typedef struct packed {
        logic        do_cfg;
        logic [3:0]  sel;
        logic [7:0]  dat;
        logic [31:0] addr;
        logic        wr;
        logic        io;
        logic        hit;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd1, 8'h31, 32'h000C0000, 1'b0, 1'b0, 1'b1, 8'd3},  // R3 01 read -> DRAM
        '{1'b0, 4'd0, 8'h00, 32'h000C0000, 1'b1, 1'b1, 1'b1, 8'd3},  // R3 01 write -> I/O
        '{1'b0, 4'd0, 8'h00, 32'h000C4000, 1'b1, 1'b0, 1'b1, 8'd4},  // R4 odd window bits[5:4]=11
        '{1'b0, 4'd0, 8'h00, 32'h000C7FFC, 1'b0, 1'b0, 1'b1, 8'd4},  // R4 window top
        '{1'b1, 4'd6, 8'h20, 32'h000EC000, 1'b1, 1'b0, 1'b1, 8'd3},  // R3 10 write -> DRAM
        '{1'b0, 4'd0, 8'h00, 32'h000EC000, 1'b0, 1'b1, 1'b1, 8'd3},  // R3 10 read -> I/O
        '{1'b0, 4'd0, 8'h00, 32'h000E8000, 1'b0, 1'b1, 1'b1, 8'd4},  // R4 window 10 still 00
        '{1'b1, 4'd3, 8'h02, 32'h000D0000, 1'b1, 1'b0, 1'b1, 8'd4},  // R4 window 4
        '{1'b0, 4'd0, 8'h00, 32'h000D0000, 1'b0, 1'b1, 1'b1, 8'd4},  // R4 window 4 read
        '{1'b0, 4'd0, 8'h00, 32'h000D4000, 1'b1, 1'b1, 1'b1, 8'd4},  // R4 window 5 untouched
        '{1'b0, 4'd0, 8'h00, 32'h000C8000, 1'b0, 1'b1, 1'b1, 8'd4},  // R4 window 2 untouched
        '{1'b1, 4'd0, 8'h13, 32'h000F0000, 1'b0, 1'b0, 1'b1, 8'd5},  // R5 firmware 01 read
        '{1'b0, 4'd0, 8'h00, 32'h000FFFFC, 1'b1, 1'b1, 1'b1, 8'd5},  // R5 firmware write
        '{1'b0, 4'd0, 8'h00, 32'h000BFFFC, 1'b0, 1'b0, 1'b0, 8'd9},  // R9 below windows
        '{1'b0, 4'd0, 8'h00, 32'h00080000, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 no hole yet
        '{1'b1, 4'd7, 8'h40, 32'h00080000, 1'b1, 1'b1, 1'b1, 8'd6},  // R6 low hole base
        '{1'b0, 4'd0, 8'h00, 32'h0009FFFC, 1'b0, 1'b1, 1'b1, 8'd6},  // R6 low hole top
        '{1'b0, 4'd0, 8'h00, 32'h000A0000, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 just above
        '{1'b0, 4'd0, 8'h00, 32'h0007FFFC, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 just below
        '{1'b0, 4'd0, 8'h00, 32'h00F00000, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 high range closed
        '{1'b1, 4'd7, 8'h80, 32'h00F00000, 1'b0, 1'b1, 1'b1, 8'd7},  // R7 high hole base
        '{1'b0, 4'd0, 8'h00, 32'h00FFFFFC, 1'b1, 1'b1, 1'b1, 8'd7},  // R7 high hole top
        '{1'b0, 4'd0, 8'h00, 32'h00080000, 1'b0, 1'b0, 1'b0, 8'd7},  // R7 low range closed
        '{1'b0, 4'd0, 8'h00, 32'h01000000, 1'b0, 1'b0, 1'b0, 8'd7},  // R7 just above
        '{1'b1, 4'd7, 8'hC0, 32'h00F00000, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 reserved code
        '{1'b0, 4'd0, 8'h00, 32'h00080000, 1'b1, 1'b0, 1'b0, 8'd8},  // R8 reserved code low
        '{1'b0, 4'd0, 8'h00, 32'h100C0000, 1'b0, 1'b0, 1'b0, 8'd9},  // R9 high-bit alias
        '{1'b1, 4'd8, 8'hFF, 32'h000C0000, 1'b1, 1'b1, 1'b1, 8'd10}, // R10 sel 8 ignored
        '{1'b1, 4'd15, 8'hFF, 32'h000E8000, 1'b0, 1'b1, 1'b1, 8'd10},// R10 sel 15 ignored
        '{1'b0, 4'd0, 8'h00, 32'h000C0000, 1'b0, 1'b0, 1'b1, 8'd10}  // R10 window 0 intact
    };

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // present one access; results are registered at the next rising edge
    task automatic access(input logic [31:0] a, input logic w);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = w;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", route_vld, 1'b0, "vld in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", route_vld, 1'b0, "vld after reset");
        check("R1", route_io,  1'b0, "io after reset");
        check("R1", route_hit, 1'b0, "hit after reset");
        access(32'h000C0000, 1'b0);
        check("R1", route_io, 1'b1, "window read after reset");
        access(32'h000F8000, 1'b1);
        check("R1", route_io, 1'b1, "firmware write after reset");
        access(32'h000E4000, 1'b0);
        check("R1", route_io, 1'b1, "window 9 read after reset");

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].do_cfg) cfg_write(VECS[i].sel, VECS[i].dat);
            access(VECS[i].addr, VECS[i].wr);
            check($sformatf("R%0d", VECS[i].req), route_vld, 1'b1, $sformatf("vec %0d vld", i));
            check($sformatf("R%0d", VECS[i].req), route_io,  VECS[i].io,  $sformatf("vec %0d io", i));
            check($sformatf("R%0d", VECS[i].req), route_hit, VECS[i].hit, $sformatf("vec %0d hit", i));
        end

        // R2: strobe lasts one cycle, results hold while idle
        access(32'h000C0000, 1'b1);          // window 0 is 01 -> I/O
        check("R2", route_io, 1'b1, "io before idle");
        @(negedge clk);
        check("R2", route_vld, 1'b0, "vld drops");
        check("R2", route_io, 1'b1, "io held");
        check("R2", route_hit, 1'b1, "hit held");

        // R2: back-to-back accesses each yield their own result
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h000C0000; acc_write = 1'b1;
        @(negedge clk);
        check("R2", route_io, 1'b1, "b2b first io");
        acc_addr = 32'h00200000; acc_write = 1'b0;
        @(negedge clk);
        acc_valid = 1'b0;
        check("R2", route_vld, 1'b1, "b2b second vld");
        check("R2", route_io, 1'b0, "b2b second io");
        check("R2", route_hit, 1'b0, "b2b second hit");

        // R11: write and access in the same cycle use the old attribute
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 4'd1; cfg_data = 8'h33;
        acc_valid = 1'b1; acc_addr = 32'h000C0000; acc_write = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0;
        check("R11", route_io, 1'b1, "same-cycle uses old 01");
        access(32'h000C0000, 1'b1);
        check("R11", route_io, 1'b0, "next access uses new 11");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule